// File: doc/BRIEF.md
# Ring-Array Bitonic Key Sorter

This block holds one unsigned key in each of `N = 2^NODE_BITS` processing nodes arranged on a ring whose link stride can be changed. A small sequencer walks a bitonic sorting network as a chain of compare-exchange steps. On each step the ring is set to stride `2^j`. Every node then reads its partner's key over either its left or its right link, and keeps the smaller or the larger of the two keys.

The outer merge phase `i` runs from 1 to `NODE_BITS`. The inner stage `j` counts down from `i-1` to 0. Each step takes one transfer cycle, in which partner keys are latched, and one select cycle, in which the nodes update. Software-free use is simple. Pulse `load_i` with all keys on `keys_i`, pulse `start_i`, and wait for `done_o`. The sorted keys then sit on `keys_o` with the smallest key at node 0.

Top module: `ring_bitonic_sorter`

## Requirements
- R1: After reset every node key on `keys_o` is zero and `done_o` is low.
- R2: A cycle with `load_i` high while idle copies each key slice of `keys_i` (node p at bits `[p*KEY_W +: KEY_W]`) into node p, visible on `keys_o` after that edge.
- R3: After a sort completes, `keys_o` is non-decreasing with node index: node 0 holds the smallest key and node N-1 the largest.
- R4: The sorted keys are a permutation of the loaded keys. Duplicate keys all survive.
- R5: `done_o` goes high exactly `NODE_BITS*(NODE_BITS+1)` clock edges after the edge that accepts `start_i`, which is two cycles for each of the `NODE_BITS*(NODE_BITS+1)/2` steps.
- R6: `done_o` stays high while idle until the next accepted `load_i` or `start_i`, and drops after that edge.
- R7: While a sort runs, `load_i` and `start_i` are ignored. Keys, result and completion time are unchanged.
- R8: Keys compare as unsigned numbers, so a key with its top bit set ranks above all keys without it.
- R9: On each step the partner of node p is `(p - 2^j) mod N` when address bit j of p is 1, and `(p + 2^j) mod N` otherwise. Node p keeps the maximum when address bit j differs from address bit i (bit `NODE_BITS` reads 0), and keeps the minimum otherwise. After the first step, pairs (2k, 2k+1) are therefore ascending for even k and descending for odd k.
- R10: When `load_i` and `start_i` are both high while idle, the load is taken and no sort starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Parallel key load strobe, taken only while idle |
| keys_i | input | N*KEY_W | Keys to load, node p in slice p |
| start_i | input | 1 | Begin a sort, taken only while idle |
| keys_o | output | N*KEY_W | Current node keys, node p in slice p |
| done_o | output | 1 | High once a sort has finished |

## Verification
The bench looks for direction errors in the min/max rule and for a swapped left/right partner choice. Either fault leaves the random, duplicate-heavy and reverse-ordered vectors out of order at node 0, or mixes up the pair directions after the first step. Signed compares show up when keys near 0x80 and 0xFF are present. A miscounted stage or phase loop raises `done_o` on the wrong edge or leaves the keys unsorted. A design that accepts a stray load or start while busy corrupts the result or shifts the completion edge.

// File: rtl/ring_sort_pkg.sv
// Shared types for the ring bitonic sorter.
// Assumes: nothing beyond the standard language.
package ring_sort_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_XFER = 2'd1,
        SQ_SEL  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ring_sort_seq.sv
// Step sequencer: walks merge phase i = 1..NODE_BITS and stage j = i-1..0,
// spending one transfer and one select cycle per step.
// Assumes: NODE_BITS >= 1; load has priority over start while idle.
module ring_sort_seq
    import ring_sort_pkg::*;
#(
    parameter int NODE_BITS = 3,
    parameter int CNT_W     = $clog2(NODE_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             start_i,
    output logic [CNT_W-1:0] phase_o,
    output logic [CNT_W-1:0] stage_o,
    output logic             xfer_o,
    output logic             sel_o,
    output logic             idle_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(NODE_BITS);

    seq_state_t       state_q;
    logic [CNT_W-1:0] phase_q;
    logic [CNT_W-1:0] stage_q;
    logic             done_q;

    // Advance the step counters and the completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            phase_q <= '0;
            stage_q <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (load_i) begin
                        done_q <= 1'b0;
                    end else if (start_i) begin
                        done_q  <= 1'b0;
                        phase_q <= CNT_W'(1);
                        stage_q <= '0;
                        state_q <= SQ_XFER;
                    end
                end
                SQ_XFER: state_q <= SQ_SEL;
                SQ_SEL: begin
                    if (stage_q == '0) begin
                        if (phase_q == LAST_PHASE) begin
                            state_q <= SQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            stage_q <= phase_q;
                            phase_q <= phase_q + CNT_W'(1);
                            state_q <= SQ_XFER;
                        end
                    end else begin
                        stage_q <= stage_q - CNT_W'(1);
                        state_q <= SQ_XFER;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign stage_o = stage_q;
    assign xfer_o  = (state_q == SQ_XFER);
    assign sel_o   = (state_q == SQ_SEL);
    assign idle_o  = (state_q == SQ_IDLE);
    assign done_o  = done_q;

    // R9
    stage_below_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_o |-> (stage_q < phase_q && phase_q <= LAST_PHASE));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !load_i && !start_i) |=> done_q);

    // R7
    done_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> idle_o);
endmodule

// File: rtl/ring_route.sv
// Reconfigurable ring links: for every node, selects the key arriving on the
// left link (p - 2^j) when address bit j is 1, else on the right link (p + 2^j).
// Assumes: stage_i < NODE_BITS while a step is in progress.
module ring_route #(
    parameter int NODE_BITS = 3,
    parameter int KEY_W     = 8,
    parameter int CNT_W     = $clog2(NODE_BITS + 1),
    parameter int NODES     = 1 << NODE_BITS
) (
    input  logic [KEY_W-1:0] key_i   [NODES],
    input  logic [CNT_W-1:0] stage_i,
    output logic [KEY_W-1:0] partner_o [NODES]
);
    for (genvar p = 0; p < NODES; p++) begin : g_node
        logic [KEY_W-1:0] cand [NODE_BITS];
        for (genvar j = 0; j < NODE_BITS; j++) begin : g_stride
            localparam int LEFT_IDX  = (p - (1 << j) + NODES) % NODES;
            localparam int RIGHT_IDX = (p + (1 << j)) % NODES;
            if (((p >> j) & 1) == 1) begin : g_left
                assign cand[j] = key_i[LEFT_IDX];
            end else begin : g_right
                assign cand[j] = key_i[RIGHT_IDX];
            end
        end
        // Pick the link matching the current stride.
        always_comb begin
            partner_o[p] = cand[0];
            for (int j = 0; j < NODE_BITS; j++) begin
                if (stage_i == CNT_W'(j)) partner_o[p] = cand[j];
            end
        end
    end
endmodule

// File: rtl/ring_node.sv
// One processing node: holds a key, latches its partner's key on the transfer
// cycle and keeps the min or max on the select cycle.
// Assumes: phase_i <= NODE_BITS and stage_i < NODE_BITS during a step.
module ring_node #(
    parameter int NODE_BITS = 3,
    parameter int KEY_W     = 8,
    parameter int ADDR      = 0,
    parameter int CNT_W     = $clog2(NODE_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en_i,
    input  logic [KEY_W-1:0] load_key_i,
    input  logic             xfer_i,
    input  logic             sel_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic [CNT_W-1:0] stage_i,
    input  logic [KEY_W-1:0] partner_i,
    output logic [KEY_W-1:0] key_o
);
    localparam logic [NODE_BITS:0] ADDR_X = (NODE_BITS + 1)'(ADDR);

    logic [KEY_W-1:0] key_q;
    logic [KEY_W-1:0] peer_q;
    logic             keep_max;
    logic [KEY_W-1:0] lo_key;
    logic [KEY_W-1:0] hi_key;

    // Decide the kept side and order the two keys as unsigned values.
    always_comb begin
        keep_max = ADDR_X[stage_i] ^ ADDR_X[phase_i];
        if (key_q <= peer_q) begin
            lo_key = key_q;
            hi_key = peer_q;
        end else begin
            lo_key = peer_q;
            hi_key = key_q;
        end
    end

    // Hold the key and the latched partner key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '0;
            peer_q <= '0;
        end else begin
            if (load_en_i)   key_q  <= load_key_i;
            else if (sel_i)  key_q  <= keep_max ? hi_key : lo_key;
            if (xfer_i)      peer_q <= partner_i;
        end
    end

    assign key_o = key_q;

    // R4
    key_conserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !load_en_i) |=> (key_q == $past(key_q) || key_q == $past(peer_q)));

    // R8
    ordered_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !load_en_i) |=>
        (keep_max == $past(keep_max)) || 1'b1 ? 
        ($past(keep_max) ? (key_q >= $past(peer_q) && key_q >= $past(key_q))
                         : (key_q <= $past(peer_q) && key_q <= $past(key_q))) : 1'b1);
endmodule

// File: rtl/ring_bitonic_sorter.sv
// Top: N nodes on a stride-switchable ring plus the step sequencer; sorts the
// loaded keys ascending by node address.
// Assumes: keys are unsigned; load and start are single-cycle strobes.
module ring_bitonic_sorter
    import ring_sort_pkg::*;
#(
    parameter int NODE_BITS = 3,
    parameter int KEY_W     = 8,
    parameter int NODES     = 1 << NODE_BITS,
    parameter int BUS_W     = NODES * KEY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [BUS_W-1:0] keys_i,
    input  logic             start_i,
    output logic [BUS_W-1:0] keys_o,
    output logic             done_o
);
    localparam int CNT_W    = $clog2(NODE_BITS + 1);
    localparam int SORT_CYC = NODE_BITS * (NODE_BITS + 1);

    logic [CNT_W-1:0] phase;
    logic [CNT_W-1:0] stage;
    logic             xfer;
    logic             sel;
    logic             idle;
    logic             load_en;
    logic [KEY_W-1:0] node_key [NODES];
    logic [KEY_W-1:0] peer_key [NODES];

    assign load_en = load_i && idle;

    ring_sort_seq #(.NODE_BITS(NODE_BITS), .CNT_W(CNT_W)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .start_i (start_i),
        .phase_o (phase),
        .stage_o (stage),
        .xfer_o  (xfer),
        .sel_o   (sel),
        .idle_o  (idle),
        .done_o  (done_o)
    );

    ring_route #(.NODE_BITS(NODE_BITS), .KEY_W(KEY_W), .CNT_W(CNT_W), .NODES(NODES)) route_i (
        .key_i     (node_key),
        .stage_i   (stage),
        .partner_o (peer_key)
    );

    for (genvar p = 0; p < NODES; p++) begin : g_pe
        ring_node #(.NODE_BITS(NODE_BITS), .KEY_W(KEY_W), .ADDR(p), .CNT_W(CNT_W)) node_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_en_i  (load_en),
            .load_key_i (keys_i[p*KEY_W +: KEY_W]),
            .xfer_i     (xfer),
            .sel_i      (sel),
            .phase_i    (phase),
            .stage_i    (stage),
            .partner_i  (peer_key[p]),
            .key_o      (node_key[p])
        );
        assign keys_o[p*KEY_W +: KEY_W] = node_key[p];
    end

    // Count cycles since the accepted start, for the completion-time check.
    logic [15:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                          run_cnt <= '0;
        else if (idle && start_i && !load_i) run_cnt <= '0;
        else if (!idle)                      run_cnt <= run_cnt + 16'd1;
    end

    // R5
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (run_cnt == 16'(SORT_CYC)));

    // R7
    busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !sel && load_i) |=> $stable(keys_o));

    // R10
    load_beats_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && load_i && start_i) |=> idle);
endmodule

// File: tb/ring_bitonic_sorter_tb_top.sv
// Scoreboard bench: the driver pushes the expected sorted vector, the monitor
// pops and compares it when done_o rises.
module ring_bitonic_sorter_tb_top;
    localparam int NODE_BITS = 3;
    localparam int KEY_W     = 8;
    localparam int NODES     = 1 << NODE_BITS;
    localparam int BUS_W     = NODES * KEY_W;
    localparam int SORT_CYC  = NODE_BITS * (NODE_BITS + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_i = 1'b0;
    logic             start_i = 1'b0;
    logic [BUS_W-1:0] keys_i = '0;
    logic [BUS_W-1:0] keys_o;
    logic             done_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [BUS_W-1:0] exp_q [$];
    logic             done_prev = 1'b0;

    always #10 clk = ~clk;

    ring_bitonic_sorter #(.NODE_BITS(NODE_BITS), .KEY_W(KEY_W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .keys_i  (keys_i),
        .start_i (start_i),
        .keys_o  (keys_o),
        .done_o  (done_o)
    );

    task automatic check(input bit ok, input string req, input logic [BUS_W-1:0] act,
                         input logic [BUS_W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [BUS_W-1:0] sorted_of(input logic [BUS_W-1:0] v);
        logic [KEY_W-1:0] a [NODES];
        logic [BUS_W-1:0] r;
        for (int p = 0; p < NODES; p++) a[p] = v[p*KEY_W +: KEY_W];
        for (int x = 0; x < NODES; x++)
            for (int y = 0; y < NODES - 1 - x; y++)
                if (a[y] > a[y+1]) begin
                    logic [KEY_W-1:0] t;
                    t = a[y]; a[y] = a[y+1]; a[y+1] = t;
                end
        for (int p = 0; p < NODES; p++) r[p*KEY_W +: KEY_W] = a[p];
        return r;
    endfunction

    // Monitor: compare the result against the scoreboard when done rises.
    always @(negedge clk) begin
        if (rst_n && done_o && !done_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 R4 unexpected done", keys_o, '0);
            end else begin
                logic [BUS_W-1:0] e;
                e = exp_q.pop_front();
                check(keys_o == e, "R3 R4 sorted permutation", keys_o, e);
            end
        end
        done_prev = done_o;
    end

    task automatic load_keys(input logic [BUS_W-1:0] v);
        @(negedge clk);
        keys_i = v; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        check(keys_o == v, "R2 load", keys_o, v);
    endtask

    // Start a sort and check the completion edge (R5); optional busy noise (R7).
    task automatic run_sort(input logic [BUS_W-1:0] v, input bit noise);
        load_keys(v);
        exp_q.push_back(sorted_of(v));
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < SORT_CYC - 1; c++) begin
            if (noise && c == 3) begin
                keys_i = ~v; load_i = 1'b1; start_i = 1'b1;
            end else begin
                load_i = 1'b0; start_i = 1'b0;
            end
            @(negedge clk);
        end
        load_i = 1'b0; start_i = 1'b0;
        check(done_o == 1'b0, "R5 done early", {{(BUS_W-1){1'b0}}, done_o}, '0);
        @(negedge clk);
        check(done_o == 1'b1, "R5 done on time", {{(BUS_W-1){1'b0}}, done_o}, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : driver
        logic [BUS_W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(keys_o == '0 && done_o == 1'b0, "R1 reset state", keys_o, '0);

        // R3 R4 fixed patterns: reverse, sorted, all equal
        for (int p = 0; p < NODES; p++) v[p*KEY_W +: KEY_W] = KEY_W'(NODES - p);
        run_sort(v, 1'b0);
        for (int p = 0; p < NODES; p++) v[p*KEY_W +: KEY_W] = KEY_W'(p * 3);
        run_sort(v, 1'b0);
        run_sort({NODES{8'h5A}}, 1'b0);

        // R8 unsigned extremes
        v = {8'h00, 8'hFF, 8'h7F, 8'h80, 8'h01, 8'hFE, 8'h81, 8'h7E};
        run_sort(v, 1'b0);
        check(keys_o[BUS_W-1 -: KEY_W] == 8'hFF && keys_o[KEY_W-1:0] == 8'h00,
              "R8 unsigned ends", keys_o, sorted_of(v));

        // R6 done holds, then drops on load
        repeat (4) @(negedge clk);
        check(done_o == 1'b1, "R6 done held", {{(BUS_W-1){1'b0}}, done_o}, 1);
        load_keys(v);
        check(done_o == 1'b0, "R6 done cleared by load", {{(BUS_W-1){1'b0}}, done_o}, 0);

        // R7 stray load and start while busy
        v = {8'h10, 8'h33, 8'h02, 8'h90, 8'h44, 8'h10, 8'hC1, 8'h07};
        run_sort(v, 1'b1);

        // R9 pair directions after the first step
        v = {8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
        load_keys(v);
        exp_q.push_back(sorted_of(v));
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < NODES / 2; k++) begin
            logic [KEY_W-1:0] a, b;
            a = keys_o[(2*k)*KEY_W +: KEY_W];
            b = keys_o[(2*k+1)*KEY_W +: KEY_W];
            check((k % 2 == 0) ? (a <= b) : (a >= b), "R9 first-step pair direction",
                  {a, b}, '0);
        end
        repeat (SORT_CYC) @(negedge clk);

        // R10 load and start together: load taken, no sort
        v = {8'h09, 8'h08, 8'h07, 8'h06, 8'h05, 8'h04, 8'h03, 8'h02};
        @(negedge clk);
        keys_i = v; load_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0; start_i = 1'b0;
        repeat (SORT_CYC + 2) @(negedge clk);
        check(keys_o == v && done_o == 1'b0, "R10 load wins over start", keys_o, v);

        // R3 R4 random vectors, many with duplicate keys
        for (int t = 0; t < 40; t++) begin
            for (int p = 0; p < NODES; p++)
                v[p*KEY_W +: KEY_W] = (t % 2 == 0) ? KEY_W'($urandom_range(0, 3))
                                                   : KEY_W'($urandom);
            run_sort(v, 1'b0);
        end

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 scoreboard drained",
              BUS_W'(exp_q.size()), '0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule